// File: doc/BRIEF.md
# Byte-Counted Video Frame Sequencer

This block paces the lines and frames of a packet-based video transmitter. Horizontal spans are programmed in bytes and vertical spans in lines. Each clock consumes a fixed number of bytes, set by the parameter `BPC`. A horizontal span of B bytes therefore lasts ceil(B / BPC) clocks.

The block has two line layouts. In pulse mode (`cfg_burst` = 0) a line runs sync, back porch, payload, front porch. In burst mode (`cfg_burst` = 1) the line has no sync span: the back-porch value is taken to already include the sync time, and the sync value is ignored.

The payload width is whatever remains of the line total after the blanking spans, and it is floored at zero. A frame runs its sync lines, back-porch lines, payload lines and front-porch lines, then starts again. The block samples every setting only at the first clock of a frame. When `en` drops, the frame in progress is completed and the block then rests in blanking.

Top module: `vid_timing_seq`

## Requirements
- R1: While reset is applied and afterwards with `en` low, `running`, `line_start`, `frame_start` and `active_en` are 0, and `v_region` = 3 and `h_region` = 3.
- R2: In pulse mode the `h_region` codes of a line run in the order 0 (sync), 1 (back porch), 2 (payload), 3 (front porch). A span of B bytes lasts ceil(B/BPC) clocks.
- R3: In burst mode code 0 never appears, `cfg_hsa` has no effect, and the payload bytes are total − hbp − hfp.
- R4: The payload bytes are total minus the blanking bytes that are in use. When that difference is negative the payload is zero bytes: code 2 is then absent from the line and `active_en` stays low for the whole line.
- R5: A sync or back-porch span of zero bytes is skipped. The front-porch span always lasts at least one clock.
- R6: The `v_region` codes run in the order 0 (sync lines), 1 (back-porch lines), 2 (payload lines), 3 (front-porch lines), each held for its programmed number of lines, and then wrap back to 0.
- R7: A setting below its minimum is raised to that minimum: sync lines, back-porch lines and payload lines to 1, front-porch lines to 2.
- R8: `active_en` is high exactly when `running` is high, `v_region` = 2 and `h_region` = 2.
- R9: `line_start` is high on the first clock of every line. `frame_start` is high only on the first clock of the first line of a frame.
- R10: A change to the settings during a frame has no effect until the next frame begins.
- R11: If `en` is low at the last clock of a frame, the block goes to the rest state of R1 on the next clock.
- R12: From rest, when `en` is sampled high at a clock edge, the clock that follows is the first clock of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run request |
| cfg_burst | input | 1 | 1 = burst layout, 0 = pulse layout |
| cfg_h_total | input | HT_W | Line total in bytes |
| cfg_hsa | input | HP_W | Sync span in bytes |
| cfg_hbp | input | HP_W | Back porch in bytes |
| cfg_hfp | input | HP_W | Front porch in bytes |
| cfg_vsa | input | VP_W | Sync lines |
| cfg_vbp | input | VP_W | Back-porch lines |
| cfg_vfp | input | VP_W | Front-porch lines |
| cfg_vact | input | VA_W | Payload lines |
| running | output | 1 | A frame is in progress |
| v_region | output | 2 | Vertical span code |
| h_region | output | 2 | Horizontal span code |
| line_start | output | 1 | First clock of a line |
| frame_start | output | 1 | First clock of a frame |
| active_en | output | 1 | Payload bytes are being consumed |

## Verification
The bench targets these cases:
- Byte counts that are not a multiple of `BPC`. A sequencer that truncates instead of rounding up would produce lines that are one clock short.
- A line whose blanking exceeds the total. Without saturation the payload count would wrap around and produce an enormous payload span.
- Zero-byte sync and back-porch spans. If these are not skipped, they show up as extra one-clock regions.
- All-zero vertical settings. These expose a missing clamp, which would make a frame that is too short or that wraps through zero.
- Settings rewritten in mid-frame. A design that follows its inputs directly would tear that frame.
- A frame that ends with `en` low. This shows whether the block stops at the frame boundary or cuts the frame short.

// File: rtl/vid_timing_seq.sv
module vid_timing_seq #(
  parameter int HT_W = 32,
  parameter int HP_W = 16,
  parameter int VP_W = 8,
  parameter int VA_W = 16,
  parameter int BPC  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            cfg_burst,
  input  logic [HT_W-1:0] cfg_h_total,
  input  logic [HP_W-1:0] cfg_hsa,
  input  logic [HP_W-1:0] cfg_hbp,
  input  logic [HP_W-1:0] cfg_hfp,
  input  logic [VP_W-1:0] cfg_vsa,
  input  logic [VP_W-1:0] cfg_vbp,
  input  logic [VP_W-1:0] cfg_vfp,
  input  logic [VA_W-1:0] cfg_vact,
  output logic            running,
  output logic [1:0]      v_region,
  output logic [1:0]      h_region,
  output logic            line_start,
  output logic            frame_start,
  output logic            active_en
);
  localparam int CW = HT_W + 2;

  function automatic logic [CW-1:0] hclk(input logic [1:0] idx, input logic [HT_W-1:0] tot,
                                         input logic [HP_W-1:0] hsa, input logic [HP_W-1:0] hbp,
                                         input logic [HP_W-1:0] hfp, input logic burst);
    logic [CW-1:0] t, b, a, bytes, c;
    t = CW'(tot);
    b = (burst ? '0 : CW'(hsa)) + CW'(hbp) + CW'(hfp);
    a = (t > b) ? t - b : '0;
    case (idx)
      2'd0:    bytes = burst ? '0 : CW'(hsa);
      2'd1:    bytes = CW'(hbp);
      2'd2:    bytes = a;
      default: bytes = CW'(hfp);
    endcase
    c = (bytes + CW'(BPC - 1)) / CW'(BPC);
    if (idx == 2'd3 && c == '0) c = CW'(1);
    return c;
  endfunction

  function automatic logic [1:0] next_h(input logic [1:0] from, input logic n0, input logic n1,
                                       input logic n2);
    if (from == 2'd0 && n0) return 2'd0;
    if (from <= 2'd1 && n1) return 2'd1;
    if (from <= 2'd2 && n2) return 2'd2;
    return 2'd3;
  endfunction

  logic            s_burst;
  logic [HT_W-1:0] s_total;
  logic [HP_W-1:0] s_hsa, s_hbp, s_hfp;
  logic [VA_W-1:0] s_vl [4];

  logic            run;
  logic [1:0]      vr, hr;
  logic [CW-1:0]   hcnt;
  logic [VA_W-1:0] vcnt;

  logic [CW-1:0]   hc [4];
  logic [CW-1:0]   in_c0, in_c1, in_c2;
  logic [1:0]      first_sh, first_in;
  logic            h_last, v_last, line_end, frame_end, ld;

  always_comb
    for (int i = 0; i < 4; i++)
      hc[i] = hclk(2'(i), s_total, s_hsa, s_hbp, s_hfp, s_burst);

  assign in_c0 = hclk(2'd0, cfg_h_total, cfg_hsa, cfg_hbp, cfg_hfp, cfg_burst);
  assign in_c1 = hclk(2'd1, cfg_h_total, cfg_hsa, cfg_hbp, cfg_hfp, cfg_burst);
  assign in_c2 = hclk(2'd2, cfg_h_total, cfg_hsa, cfg_hbp, cfg_hfp, cfg_burst);

  assign first_sh  = next_h(2'd0, hc[0] != '0, hc[1] != '0, hc[2] != '0);
  assign first_in  = next_h(2'd0, in_c0 != '0, in_c1 != '0, in_c2 != '0);
  assign h_last    = hcnt == hc[hr] - CW'(1);
  assign v_last    = vcnt == s_vl[vr] - VA_W'(1);
  assign line_end  = run && h_last && hr == 2'd3;
  assign frame_end = line_end && v_last && vr == 2'd3;
  assign ld        = en && (!run || frame_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      vr      <= 2'd3;
      hr      <= 2'd3;
      hcnt    <= '0;
      vcnt    <= '0;
      s_burst <= 1'b0;
      s_total <= '0;
      s_hsa   <= '0;
      s_hbp   <= '0;
      s_hfp   <= '0;
      for (int i = 0; i < 4; i++) s_vl[i] <= VA_W'(1);
    end else if (ld) begin
      run     <= 1'b1;
      vr      <= 2'd0;
      hr      <= first_in;
      hcnt    <= '0;
      vcnt    <= '0;
      s_burst <= cfg_burst;
      s_total <= cfg_h_total;
      s_hsa   <= cfg_hsa;
      s_hbp   <= cfg_hbp;
      s_hfp   <= cfg_hfp;
      s_vl[0] <= (cfg_vsa == '0) ? VA_W'(1) : VA_W'(cfg_vsa);
      s_vl[1] <= (cfg_vbp == '0) ? VA_W'(1) : VA_W'(cfg_vbp);
      s_vl[2] <= (cfg_vact == '0) ? VA_W'(1) : cfg_vact;
      s_vl[3] <= (cfg_vfp < VP_W'(2)) ? VA_W'(2) : VA_W'(cfg_vfp);
    end else if (frame_end) begin
      run  <= 1'b0;
      hcnt <= '0;
      vcnt <= '0;
    end else if (run) begin
      if (!h_last) begin
        hcnt <= hcnt + CW'(1);
      end else begin
        hcnt <= '0;
        if (hr != 2'd3) begin
          hr <= next_h(hr + 2'd1, hc[0] != '0, hc[1] != '0, hc[2] != '0);
        end else begin
          hr <= first_sh;
          if (v_last) begin
            vcnt <= '0;
            vr   <= vr + 2'd1;
          end else begin
            vcnt <= vcnt + VA_W'(1);
          end
        end
      end
    end
  end

  assign running     = run;
  assign v_region    = vr;
  assign h_region    = hr;
  assign active_en   = run && vr == 2'd2 && hr == 2'd2;
  assign line_start  = run && hcnt == '0 && hr == first_sh;
  assign frame_start = line_start && vr == 2'd0 && vcnt == '0;
endmodule

// File: rtl/vid_timing_seq_chk.sv
module vid_timing_seq_chk #(
  parameter int HT_W = 32,
  parameter int HP_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            running,
  input logic [1:0]      v_region,
  input logic [1:0]      h_region,
  input logic            line_start,
  input logic            frame_start,
  input logic            active_en,
  input logic [HT_W-1:0] sh_total,
  input logic [HP_W-1:0] sh_hbp
);
  // R9
  frame_in_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> line_start);

  // R8
  active_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_en |-> (running && v_region == 2'd2 && h_region == 2'd2));

  // R2
  h_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && h_region != $past(h_region) && !line_start)
      |-> h_region > $past(h_region));

  // R6
  v_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && v_region != $past(v_region))
      |-> v_region == 2'($past(v_region) + 2'd1));

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |-> ($stable(sh_total) && $stable(sh_hbp)));

  // R11
  stop_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> ($past(v_region) == 2'd3 && $past(h_region) == 2'd3));
endmodule

bind vid_timing_seq vid_timing_seq_chk #(.HT_W(HT_W), .HP_W(HP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .running(running), .v_region(v_region),
  .h_region(h_region), .line_start(line_start), .frame_start(frame_start),
  .active_en(active_en), .sh_total(s_total), .sh_hbp(s_hbp));

// File: tb/sim_vid_timing_seq.sv
module sim_vid_timing_seq;
  localparam int BPC = 4;

  typedef struct {
    int total, hsa, hbp, hfp, vsa, vbp, vfp, vact;
    bit burst;
  } cfg_t;

  logic clk = 0, rst_n = 0, en = 0, cfg_burst = 0;
  logic [31:0] cfg_h_total = '0;
  logic [15:0] cfg_hsa = '0, cfg_hbp = '0, cfg_hfp = '0, cfg_vact = '0;
  logic [7:0]  cfg_vsa = '0, cfg_vbp = '0, cfg_vfp = '0;
  logic running, line_start, frame_start, active_en;
  logic [1:0] v_region, h_region;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vid_timing_seq #(.BPC(BPC)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_burst(cfg_burst), .cfg_h_total(cfg_h_total),
    .cfg_hsa(cfg_hsa), .cfg_hbp(cfg_hbp), .cfg_hfp(cfg_hfp), .cfg_vsa(cfg_vsa),
    .cfg_vbp(cfg_vbp), .cfg_vfp(cfg_vfp), .cfg_vact(cfg_vact), .running(running),
    .v_region(v_region), .h_region(h_region), .line_start(line_start),
    .frame_start(frame_start), .active_en(active_en));

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic drive(cfg_t c);
    cfg_burst = c.burst; cfg_h_total = c.total;
    cfg_hsa = 16'(c.hsa); cfg_hbp = 16'(c.hbp); cfg_hfp = 16'(c.hfp);
    cfg_vsa = 8'(c.vsa); cfg_vbp = 8'(c.vbp); cfg_vfp = 8'(c.vfp); cfg_vact = 16'(c.vact);
  endtask

  function automatic int ceil_b(int b);
    return (b + BPC - 1) / BPC;
  endfunction

  function automatic int hclocks(cfg_t c, int idx);
    int hs, act, n;
    hs  = c.burst ? 0 : c.hsa;
    act = c.total - hs - c.hbp - c.hfp;
    if (act < 0) act = 0;
    case (idx)
      0: n = ceil_b(hs);
      1: n = ceil_b(c.hbp);
      2: n = ceil_b(act);
      default: n = (ceil_b(c.hfp) < 1) ? 1 : ceil_b(c.hfp);
    endcase
    return n;
  endfunction

  function automatic int vlines(cfg_t c, int idx);
    case (idx)
      0: return c.vsa < 1 ? 1 : c.vsa;
      1: return c.vbp < 1 ? 1 : c.vbp;
      2: return c.vact < 1 ? 1 : c.vact;
      default: return c.vfp < 2 ? 2 : c.vfp;
    endcase
  endfunction

  task automatic run_frame(string tag, cfg_t c, cfg_t nxt, bit en_next);
    int cyc = 0;
    string hreq = c.burst ? "R3" : "R2";
    for (int rv = 0; rv < 4; rv++)
      for (int ln = 0; ln < vlines(c, rv); ln++) begin
        bit first = 1;
        for (int rh = 0; rh < 4; rh++)
          for (int k = 0; k < hclocks(c, rh); k++) begin
            @(negedge clk);
            check({"R12 ", tag}, "running", running, 1);
            check({"R6 ", tag}, "v_region", v_region, rv);
            check({hreq, " ", tag}, "h_region", h_region, rh);
            check({"R8 R4 ", tag}, "active_en", active_en, (rv == 2 && rh == 2) ? 1 : 0);
            check({"R9 ", tag}, "line_start", line_start, first);
            check({"R9 ", tag}, "frame_start", frame_start, (first && rv == 0 && ln == 0) ? 1 : 0);
            first = 0;
            if (cyc == 0) begin
              drive(nxt);
              en = en_next;
            end
            cyc++;
          end
      end
  endtask

  task automatic check_rest(string req, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, "running", running, 0);
      check(req, "line_start", line_start, 0);
      check(req, "frame_start", frame_start, 0);
      check(req, "active_en", active_en, 0);
      check(req, "v_region", v_region, 3);
      check(req, "h_region", h_region, 3);
    end
  endtask

  function automatic cfg_t rand_cfg();
    cfg_t c;
    c.burst = 1'($urandom_range(0, 1));
    c.total = $urandom_range(0, 160);
    c.hsa = $urandom_range(0, 13);
    c.hbp = $urandom_range(0, 21);
    c.hfp = $urandom_range(0, 17);
    c.vsa = $urandom_range(0, 3);
    c.vbp = $urandom_range(0, 3);
    c.vact = $urandom_range(0, 5);
    c.vfp = $urandom_range(0, 4);
    return c;
  endfunction

  initial begin
    cfg_t a, b, z, s, k, r, r2;
    void'($urandom(32'h5eed_0042));
    a = '{120, 8, 12, 10, 1, 2, 2, 3, 1'b0};
    b = '{130, 8, 14, 6, 2, 1, 3, 2, 1'b1};
    z = '{40, 0, 0, 0, 0, 0, 0, 0, 1'b0};
    s = '{20, 6, 14, 10, 1, 1, 2, 2, 1'b0};
    k = '{37, 0, 0, 3, 1, 1, 2, 1, 1'b0};
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check("R1", "running(reset)", running, 0);
    check("R1", "v_region(reset)", v_region, 3);
    check("R1", "h_region(reset)", h_region, 3);
    rst_n = 1;
    check_rest("R1", 3);
    drive(a);
    en = 1;
    // R2 pulse layout; next frame settings written mid-frame (R10)
    run_frame("R2", a, b, 1);
    // R3 burst layout; R10: this frame uses b although it was written during frame a
    run_frame("R3 R10", b, z, 1);
    // R7: all vertical settings zero, clamped
    run_frame("R7", z, s, 1);
    // R4: blanking exceeds the total, payload saturates at zero
    run_frame("R4", s, k, 1);
    // R5: zero sync/back porch skipped, odd byte counts round up
    r = rand_cfg();
    run_frame("R5", k, r, 1);
    for (int i = 0; i < 18; i++) begin
      r2 = rand_cfg();
      run_frame("RND", r, r2, 1);
      r = r2;
    end
    // R11: en dropped mid-frame, frame completes then rests
    run_frame("R11", r, a, 0);
    check_rest("R11", 4);
    // R12: restart from rest
    @(negedge clk);
    drive(b);
    en = 1;
    run_frame("R12", b, b, 0);
    check_rest("R11", 2);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule